// File: doc/BRIEF.md
# Supply supervisor with watchdog

This block drives a single active-low system reset from two independent causes. The first is an under-voltage flag from an external supply comparator. The second is a watchdog that expects software to keep producing falling edges on a shared chip-select / watchdog-kick line. After either cause, reset stays asserted for a fixed hold interval. The same condition also drives a communication-inhibit output. The serial interface uses that output to abort any transfer in flight and to refuse new ones.

A raw power-good flag acts as the asynchronous power-on clear of the whole block. It releases into the clock domain through a synchronizer. The below-trip flag and the chip-select line each pass through their own synchronizer before any logic uses them. A two-bit period code, normally held in a status register, picks one of three watchdog timeouts or turns the watchdog off. The hold time and all three timeouts are parameters counted in clock cycles.

Top module: `supply_guard`

## Requirements
- R1: While `por_ok` is low, `sys_rst_n` is low and `comm_block` is high, with no clock edge needed.
- R2: After `por_ok` rises, with `below_trip` low, `sys_rst_n` first reads high HOLD_CYC+2 rising clock edges later (two synchronizer edges plus the hold count).
- R3: `below_trip` high drives `sys_rst_n` low and `comm_block` high after exactly two rising edges, whatever the watchdog state or hold progress.
- R4: Reset stays asserted for as long as `below_trip` is high. It releases HOLD_CYC+2 rising edges after `below_trip` falls.
- R5: A high pulse on `below_trip` during the hold interval, even a single cycle long, restarts the full hold. Release then comes HOLD_CYC+2 edges after the pulse ends.
- R6: `comm_block` is high in exactly the cycles where `sys_rst_n` is low.
- R7: A falling edge on `cs_wdi` restarts the watchdog count. Falling edges spaced no more than T cycles apart never let the watchdog assert reset.
- R8: A rising edge on `cs_wdi` does not restart the count. Reset asserts T+3 rising edges after the last falling edge, even if the line rose in between.
- R9: A `cs_wdi` held low also times out, T+3 edges after its falling edge. After each release it times out again every T cycles while the line stays low.
- R10: `wd_sel` selects the timeout T as follows: 2'b00 gives WD_T0, 2'b01 gives WD_T1 and 2'b10 gives WD_T2.
- R11: `wd_sel` = 2'b11 disables the watchdog. Reset never asserts from it, however long `cs_wdi` stays idle.
- R12: A watchdog reset lasts exactly HOLD_CYC cycles and then releases. The count restarts from zero at release, so with no kick the next timeout follows T cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_ok | input | 1 | Raw power-good flag; low clears the block asynchronously |
| below_trip | input | 1 | Supply below threshold, from the external comparator (asynchronous) |
| cs_wdi | input | 1 | Chip-select / watchdog kick line; falling edges restart the watchdog |
| wd_sel | input | 2 | Watchdog period code from the status register |
| sys_rst_n | output | 1 | Active-low system reset |
| comm_block | output | 1 | High while serial traffic must be aborted and refused |

## Verification
The bench measures release latency exactly, in clock edges, after power-up, after a long brownout and after a one-cycle dip inside the hold window. A design that kept the partial hold count after the dip would release early and fail the edge count. For each timeout code it checks three cases: a falling edge followed by a rise, a line stuck low, and steady kicks at exactly the timeout spacing. A design that also restarted on rising edges, or that counted one cycle too many or too few, would move the assertion point or fire between kicks. It also checks the watchdog reset's length and the restart interval after it, along with the disabled code over a long idle window. A counter that was not cleared at release would show up as a short second timeout.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef enum logic [1:0] {
    WD_SHORT = 2'b00,
    WD_MID   = 2'b01,
    WD_LONG  = 2'b10,
    WD_OFF   = 2'b11
  } wd_sel_e;
endpackage

// File: rtl/sg_sync.sv
// Multi-stage synchronizer with asynchronous clear to a chosen value.
module sg_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] st_q;
  logic [STAGES-1:0] st_d;

  always_comb begin
    st_d[0] = d;
    for (int i = 1; i < STAGES; i++) begin
      st_d[i] = st_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= {STAGES{RST_VAL}};
    end else begin
      st_q <= st_d;
    end
  end

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/sg_hold.sv
// Reset hold: any trigger (re)starts a full HOLD_CYC interval.
module sg_hold #(
  parameter int HOLD_CYC = 20,
  localparam int CW = $clog2(HOLD_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic low_supply,
  input  logic wd_trip,
  output logic rst_now
);
  logic          active_q, active_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    cnt_en   = 1'b0;
    if (low_supply || wd_trip) begin
      active_d = 1'b1;
      cnt_d    = '0;
      cnt_en   = 1'b1;
    end else if (active_q) begin
      cnt_en = 1'b1;
      if (cnt_q == CW'(HOLD_CYC - 1)) begin
        active_d = 1'b0;
        cnt_d    = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (cnt_en) begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
    end
  end

  // below-trip bypasses the register so reset follows the supply at once
  assign rst_now = active_q | low_supply;
endmodule

// File: rtl/sg_wdog.sv
// Watchdog: restarted only by falling edges of the synchronized select line.
module sg_wdog
  import sg_pkg::*;
#(
  parameter int WD_T0 = 16,
  parameter int WD_T1 = 32,
  parameter int WD_T2 = 64,
  localparam int WD_MAX = (WD_T0 > WD_T1) ? ((WD_T0 > WD_T2) ? WD_T0 : WD_T2)
                                          : ((WD_T1 > WD_T2) ? WD_T1 : WD_T2),
  localparam int CW = $clog2(WD_MAX + 1)
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cs_s,
  input  wd_sel_e sel,
  input  logic    hold_off,
  output logic    trip
);
  logic          cs_prev_q;
  logic          fall;
  logic          enabled;
  logic [CW-1:0] limit;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    case (sel)
      WD_SHORT: limit = CW'(WD_T0);
      WD_MID:   limit = CW'(WD_T1);
      WD_LONG:  limit = CW'(WD_T2);
      default:  limit = CW'(WD_MAX);
    endcase
  end

  assign fall    = cs_prev_q & ~cs_s;
  assign enabled = (sel != WD_OFF);
  assign trip    = enabled & ~hold_off & ~fall & (cnt_q == limit - 1'b1);

  always_comb begin
    cnt_en = enabled | (cnt_q != '0);
    if (hold_off || fall || !enabled || trip) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev_q <= 1'b1;
    end else begin
      cs_prev_q <= cs_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/supply_guard.sv
module supply_guard
  import sg_pkg::*;
#(
  parameter int HOLD_CYC    = 10_000_000,
  parameter int WD_T0       = 7_500_000,
  parameter int WD_T1       = 30_000_000,
  parameter int WD_T2       = 70_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       por_ok,
  input  logic       below_trip,
  input  logic       cs_wdi,
  input  logic [1:0] wd_sel,
  output logic       sys_rst_n,
  output logic       comm_block
);
  logic rst_int_n;
  logic bt_s;
  logic cs_s;
  logic rst_now;
  logic wd_trip;

  sg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_por_sync (
    .clk(clk), .rst_n(por_ok), .d(1'b1), .q(rst_int_n)
  );

  sg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_bt_sync (
    .clk(clk), .rst_n(rst_int_n), .d(below_trip), .q(bt_s)
  );

  sg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst_n(rst_int_n), .d(cs_wdi), .q(cs_s)
  );

  sg_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk(clk), .rst_n(rst_int_n), .low_supply(bt_s),
    .wd_trip(wd_trip), .rst_now(rst_now)
  );

  sg_wdog #(.WD_T0(WD_T0), .WD_T1(WD_T1), .WD_T2(WD_T2)) u_wdog (
    .clk(clk), .rst_n(rst_int_n), .cs_s(cs_s),
    .sel(wd_sel_e'(wd_sel)), .hold_off(rst_now), .trip(wd_trip)
  );

  assign sys_rst_n  = ~rst_now;
  assign comm_block = rst_now;
endmodule

// File: rtl/sg_checker.sv
module sg_checker #(
  parameter int HOLD_CYC = 20,
  parameter int WD_T0    = 16,
  parameter int WD_T1    = 32,
  parameter int WD_T2    = 64
) (
  input logic clk,
  input logic por_ok,
  input logic below_trip,
  input logic cs_wdi,
  input logic sys_rst_n,
  input logic comm_block
);
  localparam int WD_MIN = (WD_T0 < WD_T1) ? ((WD_T0 < WD_T2) ? WD_T0 : WD_T2)
                                          : ((WD_T1 < WD_T2) ? WD_T1 : WD_T2);
  logic [31:0] low_q;
  logic [31:0] gap_q;
  logic        cs_d;

  always_ff @(posedge clk or negedge por_ok) begin
    if (!por_ok) begin
      low_q <= '0;
      gap_q <= '0;
      cs_d  <= 1'b1;
    end else begin
      cs_d  <= cs_wdi;
      low_q <= sys_rst_n ? '0 : ((low_q == '1) ? low_q : low_q + 1'b1);
      gap_q <= (cs_d && !cs_wdi) ? '0 : ((gap_q == '1) ? gap_q : gap_q + 1'b1);
    end
  end

  assert_por_hold_R1: assert property (@(posedge clk)
    (!por_ok && $past(!por_ok)) |-> (!sys_rst_n && comm_block));

  assert_release_len_R2: assert property (@(posedge clk) disable iff (!por_ok)
    $rose(sys_rst_n) |-> (low_q >= 32'(HOLD_CYC)));

  assert_brownout_R3: assert property (@(posedge clk) disable iff (!por_ok)
    $past(below_trip, 2) |-> (!sys_rst_n && comm_block));

  assert_kick_gap_R7: assert property (@(posedge clk) disable iff (!por_ok)
    $fell(sys_rst_n) |-> ($past(below_trip, 2) || (gap_q >= 32'(WD_MIN))));
endmodule

bind supply_guard sg_checker #(
  .HOLD_CYC(HOLD_CYC), .WD_T0(WD_T0), .WD_T1(WD_T1), .WD_T2(WD_T2)
) u_sg_chk (
  .clk(clk), .por_ok(por_ok), .below_trip(below_trip), .cs_wdi(cs_wdi),
  .sys_rst_n(sys_rst_n), .comm_block(comm_block)
);

// File: tb/supply_guard_test.sv
module supply_guard_test;
  localparam int H  = 20;
  localparam int TA = 12;
  localparam int TB = 20;
  localparam int TC = 36;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       por_ok, below_trip, cs_wdi;
  logic [1:0] wd_sel;
  logic       sys_rst_n, comm_block;

  int  errors = 0;
  int  checks = 0;
  int  mism   = 0;
  bit  done   = 1'b0;

  supply_guard #(.HOLD_CYC(H), .WD_T0(TA), .WD_T1(TB), .WD_T2(TC)) uut (
    .clk(clk), .por_ok(por_ok), .below_trip(below_trip), .cs_wdi(cs_wdi),
    .wd_sel(wd_sel), .sys_rst_n(sys_rst_n), .comm_block(comm_block)
  );

  function automatic int tmo(input int c);
    case (c)
      0:       return TA;
      1:       return TB;
      default: return TC;
    endcase
  endfunction

  task automatic chk_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_level(input logic lvl, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (sys_rst_n !== lvl && n < 1000);
  endtask

  // falling edge now, rising edge two cycles later, then wait for reset
  task automatic kick_measure(output int n);
    cs_wdi = 1'b0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 2) cs_wdi = 1'b1;
    end while (sys_rst_n !== 1'b0 && n < 1000);
  endtask

  // R6 monitor on every sample point
  always @(negedge clk) begin
    if (por_ok === 1'b1 && comm_block !== ~sys_rst_n) mism++;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL timeout: actual 100000 cycles expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    int lows;
    por_ok = 1'b1; below_trip = 1'b0; cs_wdi = 1'b1; wd_sel = 2'b11;
    #5 por_ok = 1'b0;
    repeat (4) @(negedge clk);
    chk_eq("R1 reset during power-off", int'(sys_rst_n), 0);
    chk_eq("R1 inhibit during power-off", int'(comm_block), 1);

    por_ok = 1'b1;
    wait_level(1'b1, n);
    chk_eq("R2 power-up release edges", n, H + 2);
    chk_eq("R2 inhibit released", int'(comm_block), 0);

    repeat (3) @(negedge clk);
    below_trip = 1'b1;
    @(negedge clk);
    chk_eq("R3 one edge after drop", int'(sys_rst_n), 1);
    @(negedge clk);
    chk_eq("R3 reset after two edges", int'(sys_rst_n), 0);
    chk_eq("R3 inhibit after two edges", int'(comm_block), 1);
    repeat (40) @(negedge clk);
    chk_eq("R4 held while below trip", int'(sys_rst_n), 0);
    below_trip = 1'b0;
    wait_level(1'b1, n);
    chk_eq("R4 release edges after recovery", n, H + 2);

    below_trip = 1'b1;
    repeat (3) @(negedge clk);
    below_trip = 1'b0;
    repeat (H / 2) @(negedge clk);
    chk_eq("R5 still in hold", int'(sys_rst_n), 0);
    below_trip = 1'b1;
    @(negedge clk);
    below_trip = 1'b0;
    wait_level(1'b1, n);
    chk_eq("R5 dip restarts full hold", n, H + 2);

    for (int c = 0; c < 3; c++) begin
      int t;
      t = tmo(c);
      wd_sel = c[1:0];
      kick_measure(n);
      chk_eq($sformatf("R8 R10 timeout after kick, code %0d", c), n, t + 3);
      wait_level(1'b1, n);
      chk_eq($sformatf("R12 watchdog hold length, code %0d", c), n, H);
      wait_level(1'b0, n);
      chk_eq($sformatf("R12 restart after release, code %0d", c), n, t);
      wait_level(1'b1, n);
      cs_wdi = 1'b0;
      wait_level(1'b0, n);
      chk_eq($sformatf("R9 stuck low timeout, code %0d", c), n, t + 3);
      wait_level(1'b1, n);
      wait_level(1'b0, n);
      chk_eq($sformatf("R9 stuck low repeats, code %0d", c), n, t);
      wait_level(1'b1, n);
      cs_wdi = 1'b1;
      repeat (3) @(negedge clk);
      lows = 0;
      for (int k = 0; k < 5; k++) begin
        cs_wdi = 1'b0;
        for (int j = 1; j <= t; j++) begin
          @(negedge clk);
          if (j == 2) cs_wdi = 1'b1;
          if (sys_rst_n !== 1'b1) lows++;
        end
      end
      chk_eq($sformatf("R7 kicks at timeout spacing, code %0d", c), lows, 0);
    end

    wd_sel = 2'b11;
    lows = 0;
    repeat (3 * TC) begin
      @(negedge clk);
      if (sys_rst_n !== 1'b1) lows++;
    end
    chk_eq("R11 watchdog disabled", lows, 0);

    chk_eq("R6 inhibit tracks reset", mism, 0);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule